// File: doc/BRIEF.md
# Segment Column Line Loader

This block gathers one display line of pixel bits for a dot-matrix column driver. Data arrives on a shared parallel bus, one word per shift-clock cycle. A width input chooses between a full byte per cycle and a nibble per cycle; in nibble mode two cycles are packed into one byte. Each completed byte goes into one 8-bit group of a 240-bit data latch. A one-hot group pointer names that group, and it walks the latch either upward or downward.

Several such blocks can hang on one data bus as a cascade. A line pulse rewinds every block. Each block then waits for its enable input before it accepts data. Once it has counted a full line of bits, it raises its enable output, which selects the next block in the chain, and it ignores the bus from then on. When the line pulse falls, the whole data latch is copied into the line latch that drives the column outputs. A blanking input forces all outputs low without disturbing the stored line.

Top module: `seg_line_loader`

## Requirements
- R1: While reset is asserted and just after it is released, `lineOut` is all zeros and `enOut` is low.
- R2: When `wide8` is 1, each accepted cycle writes `dataIn[7:0]` into one group. Group g occupies latch bits 8g+7 down to 8g.
- R3: When `wide8` is 0, the byte is built from `dataIn[3:0]` over two accepted cycles. The first nibble becomes bits 7:4 of the byte and the second becomes bits 3:0.
- R4: After a line pulse, bus cycles are ignored until a cycle in which `lineP` is low and `enIn` is high. That cycle's data is the first accepted data, and every later cycle is accepted until the line is full.
- R5: After 30 bytes have been written, `enOut` rises on the next clock and stays high until a cycle in which `lineP` is sampled high. Bus data arriving while `enOut` is high is ignored.
- R6: A sampled falling edge of `lineP` (high at one clock edge, low at the next) copies the data latch into the line latch at the second edge. At all other times the line latch keeps its value.
- R7: When `dirRev` is 0, the first byte of a line goes to group 0 and later bytes go to ascending groups. When `dirRev` is 1, the first byte goes to group 29 and later bytes go to descending groups.
- R8: While `dispOff` is 1, `lineOut` is all zeros. The stored line reappears as soon as `dispOff` returns to 0.
- R9: Every cycle in which `lineP` is high does the following: it clears the byte count and the nibble phase, it rewinds the group pointer to the first group for the current `dirRev`, it drops `enOut`, and it accepts no data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lineP | input | 1 | Line pulse, sampled on the shift clock |
| wide8 | input | 1 | 1: byte per cycle, 0: nibble per cycle |
| dirRev | input | 1 | 1: fill groups from the top down |
| enIn | input | 1 | Cascade select from the previous block |
| dataIn | input | 8 | Shared data bus |
| dispOff | input | 1 | Force all column outputs to blank (0) |
| enOut | output | 1 | Cascade select toward the next block |
| lineOut | output | 240 | Line latch contents, gated by blanking |

## Verification
The assertions make four assumptions about the inputs:
- `lineP` is a synchronous level, sampled on the shift clock, and it stays high for at least one clock.
- `lineP` is low during reset.
- `wide8` and `dirRev` change only while `lineP` is high.
- `dispOff` may change at any time.

The stimulus follows these assumptions. It changes the width and the direction only just before a line pulse. It raises `enIn` for exactly one cycle at the start of each line, and it keeps driving non-zero junk on the bus before selection and after the line is full. A nibble-mode line is abandoned halfway through a byte, to show that the nibble phase restarts.

// File: rtl/seg_loader_pkg.sv
package seg_loader_pkg;

  typedef enum logic [1:0] {
    WAIT_SEL  = 2'd0,
    LOADING   = 2'd1,
    LINE_FULL = 2'd2
  } ctrlState_t;

  // Strobes from the control to the datapath, all valid for one clock.
  typedef struct packed {
    logic rewind;     // line pulse high: reset the group pointer
    logic takeHi;     // hold the upper nibble
    logic writeByte;  // write the assembled byte into the pointed group
    logic transfer;   // copy the data latch into the line latch
  } loadStrobes_t;

endpackage

// File: rtl/seg_load_ctrl.sv
module seg_load_ctrl
  import seg_loader_pkg::*;
#(
  parameter int NUM_GROUPS = 30
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         lineP,
  input  logic         wide8,
  input  logic         enIn,
  output loadStrobes_t strb,
  output logic         enOut
);
  localparam int CNT_W = $clog2(NUM_GROUPS + 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(NUM_GROUPS - 1);

  ctrlState_t       state;
  logic [CNT_W-1:0] byteCnt;
  logic             nibPhase;
  logic             lpPrev;
  logic             accept;
  logic             byteDone;

  assign accept   = !lineP && ((state == WAIT_SEL && enIn) || state == LOADING);
  assign byteDone = accept && (wide8 || nibPhase);

  always_comb begin
    strb.rewind    = lineP;
    strb.takeHi    = accept && !wide8 && !nibPhase;
    strb.writeByte = byteDone;
    strb.transfer  = lpPrev && !lineP;
  end

  assign enOut = (state == LINE_FULL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= WAIT_SEL;
      byteCnt  <= '0;
      nibPhase <= 1'b0;
      lpPrev   <= 1'b0;
    end else begin
      lpPrev <= lineP;
      if (lineP) begin
        state    <= WAIT_SEL;
        byteCnt  <= '0;
        nibPhase <= 1'b0;
      end else if (accept) begin
        if (state == WAIT_SEL) state <= LOADING;
        if (!wide8) nibPhase <= ~nibPhase;
        if (byteDone) begin
          byteCnt <= byteCnt + 1'b1;
          if (byteCnt == LAST_CNT) state <= LINE_FULL;
        end
      end
    end
  end
endmodule

// File: rtl/seg_load_data.sv
module seg_load_data
  import seg_loader_pkg::*;
#(
  parameter int LINE_BITS = 240,
  parameter int BYTE_W    = 8
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  loadStrobes_t                      strb,
  input  logic                              wide8,
  input  logic                              dirRev,
  input  logic                              dispOff,
  input  logic [BYTE_W-1:0]                 dataIn,
  output logic [LINE_BITS/BYTE_W-1:0]       groupSel,
  output logic [LINE_BITS-1:0]              lineLatchQ,
  output logic [LINE_BITS-1:0]              lineOut
);
  localparam int NUM_GROUPS = LINE_BITS / BYTE_W;
  localparam int NIB_W      = BYTE_W / 2;
  localparam logic [NUM_GROUPS-1:0] FIRST_FWD = NUM_GROUPS'(1);
  localparam logic [NUM_GROUPS-1:0] FIRST_REV = FIRST_FWD << (NUM_GROUPS - 1);

  logic [NIB_W-1:0]     nibHold;
  logic [BYTE_W-1:0]    byteVal;
  logic [LINE_BITS-1:0] dataLatch;

  assign byteVal = wide8 ? dataIn : {nibHold, dataIn[NIB_W-1:0]};
  assign lineOut = dispOff ? '0 : lineLatchQ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nibHold    <= '0;
      groupSel   <= FIRST_FWD;
      lineLatchQ <= '0;
    end else begin
      if (strb.transfer) lineLatchQ <= dataLatch;
      if (strb.takeHi) nibHold <= dataIn[NIB_W-1:0];
      if (strb.rewind)
        groupSel <= dirRev ? FIRST_REV : FIRST_FWD;
      else if (strb.writeByte)
        groupSel <= dirRev ? (groupSel >> 1) : (groupSel << 1);
    end
  end

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_group
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        dataLatch[g*BYTE_W +: BYTE_W] <= '0;
      else if (strb.writeByte && groupSel[g])
        dataLatch[g*BYTE_W +: BYTE_W] <= byteVal;
    end
  end
endmodule

// File: rtl/seg_line_loader.sv
module seg_line_loader
  import seg_loader_pkg::*;
#(
  parameter int LINE_BITS = 240,
  parameter int BYTE_W    = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 lineP,
  input  logic                 wide8,
  input  logic                 dirRev,
  input  logic                 enIn,
  input  logic [BYTE_W-1:0]    dataIn,
  input  logic                 dispOff,
  output logic                 enOut,
  output logic [LINE_BITS-1:0] lineOut
);
  localparam int NUM_GROUPS = LINE_BITS / BYTE_W;

  loadStrobes_t          strb;
  logic [NUM_GROUPS-1:0] groupSel;
  logic [LINE_BITS-1:0]  lineLatchQ;

  seg_load_ctrl #(.NUM_GROUPS(NUM_GROUPS)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .lineP(lineP), .wide8(wide8),
    .enIn(enIn), .strb(strb), .enOut(enOut)
  );

  seg_load_data #(.LINE_BITS(LINE_BITS), .BYTE_W(BYTE_W)) data_i (
    .clk(clk), .rst_n(rst_n), .strb(strb), .wide8(wide8), .dirRev(dirRev),
    .dispOff(dispOff), .dataIn(dataIn), .groupSel(groupSel),
    .lineLatchQ(lineLatchQ), .lineOut(lineOut)
  );
endmodule

// File: rtl/seg_loader_chk.sv
module seg_loader_chk #(
  parameter int LINE_BITS  = 240,
  parameter int NUM_GROUPS = 30
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  lineP,
  input logic                  dispOff,
  input logic                  enOut,
  input logic [LINE_BITS-1:0]  lineOut,
  input logic [LINE_BITS-1:0]  lineLatchQ,
  input logic [NUM_GROUPS-1:0] groupSel
);
  logic seenLp;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) seenLp <= 1'b0;
    else        seenLp <= lineP;

  // R5: once raised, the cascade enable holds while no line pulse arrives
  a_r5_enable_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (enOut && !lineP) |=> enOut);

  // R9: a line pulse drops the cascade enable
  a_r9_pulse_drops_enable: assert property (@(posedge clk) disable iff (!rst_n)
    lineP |=> !enOut);

  // R6: the line latch moves only on a sampled falling line pulse
  a_r6_latch_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !(seenLp && !lineP) |=> $stable(lineLatchQ));

  // R8: blanking forces every output low
  a_r8_blank_outputs: assert property (@(posedge clk) disable iff (!rst_n)
    dispOff |-> (lineOut == '0));

  // R2: exactly one group is pointed at
  a_r2_pointer_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    !enOut |-> ($countones(groupSel) == 1));
endmodule

bind seg_line_loader seg_loader_chk #(
  .LINE_BITS(LINE_BITS), .NUM_GROUPS(NUM_GROUPS)
) chk_i (
  .clk(clk), .rst_n(rst_n), .lineP(lineP), .dispOff(dispOff), .enOut(enOut),
  .lineOut(lineOut), .lineLatchQ(lineLatchQ), .groupSel(groupSel)
);

// File: tb/seg_line_loader_tb.sv
module seg_line_loader_tb_top;
  localparam int LB = 240;
  localparam int NG = 30;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lineP = 1'b0, wide8 = 1'b1, dirRev = 1'b0, enIn = 1'b0, dispOff = 1'b0;
  logic [7:0] dataIn = '0;
  logic enOut;
  logic [LB-1:0] lineOut;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #10 clk = ~clk;

  seg_line_loader dut_i (
    .clk(clk), .rst_n(rst_n), .lineP(lineP), .wide8(wide8), .dirRev(dirRev),
    .enIn(enIn), .dataIn(dataIn), .dispOff(dispOff), .enOut(enOut), .lineOut(lineOut)
  );

  // behavioural reference
  logic [LB-1:0] mLatch, mLine;
  logic [3:0] mHold;
  int mPtr, mCnt, mState;
  bit mPhase, mLpPrev;

  task automatic mWrite(input logic [7:0] b);
    mLatch[mPtr*8 +: 8] = b;
    mCnt++;
    mPtr = dirRev ? mPtr - 1 : mPtr + 1;
    if (mCnt == NG) mState = 2;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mLatch = '0; mLine = '0; mHold = '0; mPtr = 0; mCnt = 0;
      mState = 0; mPhase = 0; mLpPrev = 0;
    end else begin
      if (mLpPrev && !lineP) mLine = mLatch;
      mLpPrev = lineP;
      if (lineP) begin
        mState = 0; mCnt = 0; mPhase = 0; mPtr = dirRev ? NG - 1 : 0;
      end else if ((mState == 0 && enIn) || mState == 1) begin
        mState = 1;
        if (wide8) mWrite(dataIn);
        else if (!mPhase) begin mHold = dataIn[3:0]; mPhase = 1; end
        else begin mWrite({mHold, dataIn[3:0]}); mPhase = 0; end
      end
    end
  end

  task automatic check(input string req, input logic [LB-1:0] act, input logic [LB-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // every-clock comparison against the reference
  always @(negedge clk) if (rst_n && !done) begin
    check("R6 lineOut vs model", lineOut, dispOff ? '0 : mLine);
    check("R5 enOut vs model", LB'(enOut), LB'(mState == 2));
  end

  task automatic step(input logic lp, input logic en, input logic [7:0] d);
    @(posedge clk); #1;
    lineP = lp; enIn = en; dataIn = d;
  endtask

  task automatic pulse();
    step(1'b1, 1'b0, 8'h00);
    step(1'b0, 1'b0, 8'h00);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 8'hFF);
  endtask

  task automatic load8(input logic [7:0] base);
    for (int k = 0; k < NG; k++) step(1'b0, k == 0, base + 8'(k));
  endtask

  task automatic load4(input logic [7:0] base);
    for (int k = 0; k < NG; k++) begin
      logic [7:0] b;
      b = base + 8'(k);
      step(1'b0, k == 0, {4'hA, b[7:4]});
      step(1'b0, 1'b0, {4'h5, b[3:0]});
    end
  endtask

  task automatic summary();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
  end

  initial begin
    #45;
    check("R1 lineOut in reset", lineOut, '0);
    check("R1 enOut in reset", LB'(enOut), '0);
    @(posedge clk); #1 rst_n = 1'b1;
    @(posedge clk); #5;
    check("R1 lineOut after reset", lineOut, '0);
    check("R1 enOut after reset", LB'(enOut), '0);

    // forward byte-wide line; junk before select must be ignored (R4)
    pulse();
    step(1'b0, 1'b0, 8'hEE); step(1'b0, 1'b0, 8'hEE); step(1'b0, 1'b0, 8'hEE);
    load8(8'h01);
    idle(4);                 // junk after full is ignored (R5)
    #5 check("R5 enOut high after full line", LB'(enOut), LB'(1));
    dirRev = 1'b1; wide8 = 1'b0;
    pulse();
    idle(2);
    #5 check("R2 group 0 first byte", LB'(lineOut[7:0]), LB'(8'h01));
    check("R2 group 29 last byte", LB'(lineOut[239:232]), LB'(8'h1E));
    check("R4 junk before select ignored", LB'(lineOut[15:8]), LB'(8'h02));
    check("R9 enOut dropped by pulse", LB'(enOut), '0);

    // reverse nibble line
    load4(8'h40);
    idle(3);
    #5 check("R6 no transfer without falling pulse", LB'(lineOut[7:0]), LB'(8'h01));
    pulse();
    idle(2);
    #5 check("R7 R3 reverse first byte in group 29", LB'(lineOut[239:232]), LB'(8'h40));
    check("R7 reverse last byte in group 0", LB'(lineOut[7:0]), LB'(8'h5D));

    dispOff = 1'b1;
    idle(1);
    #5 check("R8 blanked output", lineOut, '0);
    dispOff = 1'b0;
    idle(1);
    #5 check("R8 line restored", LB'(lineOut[239:232]), LB'(8'h40));

    // R9: abandon a line mid-byte, restart in forward nibble mode
    dirRev = 1'b0;
    pulse();
    step(1'b0, 1'b1, 8'h0C);
    pulse();
    load4(8'h80);
    pulse();
    idle(2);
    #5 check("R9 phase and pointer restart", LB'(lineOut[7:0]), LB'(8'h80));
    check("R9 last group after restart", LB'(lineOut[239:232]), LB'(8'h9D));
    summary();
  end
endmodule